// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 4-bit successive-approximation converter. A one-cycle start pulse, seen while the block is idle, begins a conversion. The block then settles one result bit per clock, starting at the most significant bit. On each step it puts a trial code on the DAC input lines. In that code the bit being decided is held at 0, every lower bit is set to 1, and every higher bit keeps the value already decided for it. At the next clock edge it stores the comparator's single-bit verdict as the value of the bit being decided.

After the least significant bit is stored, the finished word goes into a result register and the done flag rises. The host reads the word through a data bus output, which carries the result only while output enable is high. The DAC and the comparator are outside this block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `convDone` is 0, the result register is 0 (`dataBus` reads 0 with `outEn` high), and `dacCode` is 0 while idle.
- R2: A `startConv` pulse sampled at a rising edge while idle is accepted. From the next cycle `dacCode` presents the first trial code, in which bit 3 is 0 and bits 2..0 are 1 (0111).
- R3: While bit k is being decided, `dacCode[k]` is 0, every bit below k is 1, and every bit above k equals the value already stored for it.
- R4: At the end of each step, `cmpBelow` is stored as the value of the bit being decided. A value of 1 means the trial code is below the input. Because the comparator reports 0 on equality, an exact match gives a 0 bit. For input level 2 the trial codes are 0111, 0011, 0001, 0010, and the result is 0010.
- R5: `convDone` rises exactly four clock edges after the accepting edge, and the result then equals the input level for each of the 16 levels 0..15. `convDone` is 0 in the cycle after a start is accepted.
- R6: A `startConv` pulse that arrives while a conversion is in progress is ignored. The trial sequence, the completion time and the result are those of the conversion already running.
- R7: The result presented on `dataBus` stays at the previous conversion's value until the next conversion completes.
- R8: `dataBus` equals the result while `outEn` is 1 and is all zeros while `outEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rst | input | 1 | Synchronous active-high reset |
| startConv | input | 1 | Start-of-conversion pulse |
| cmpBelow | input | 1 | Comparator verdict: 1 when the trial code is below the input |
| outEn | input | 1 | Output enable for the data bus |
| dacCode | output | 4 | Trial code driven to the DAC |
| convDone | output | 1 | Conversion complete, result valid |
| dataBus | output | 4 | Result when enabled, zeros otherwise |

## Verification
An internal fault shows up on `dacCode` in the very next cycle. If the step index is wrong, the 0 falls on the wrong bit. If a stored bit is corrupted, the upper part of the following trial code is wrong. A bad sequencer count moves the rising edge of `convDone` away from the fourth edge after the start. A fault in the result register appears on `dataBus` as soon as the register loads, and with `outEn` high the bench sees it in the same cycle. Checking the trial code at every step and the result for all 16 levels, including the exact-equality cases, catches these faults within one conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;   // start accepted: wipe the working word
    logic latch;   // a bit is under test this cycle
    logic commit;  // last bit: copy finished word to result
  } sarStrobe_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          startConv,
  output sarStrobe_t    strobe,
  output logic [IW-1:0] bitIdx,
  output logic          convDone
);

  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  seqState_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      bitIdx   <= '0;
      convDone <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (startConv) begin
            state    <= SEQ_RUN;
            bitIdx   <= TOP_IDX;
            convDone <= 1'b0;
          end
        end
        SEQ_RUN: begin
          if (bitIdx == '0) begin
            state    <= SEQ_IDLE;
            convDone <= 1'b1;
          end else begin
            bitIdx <= bitIdx - IW'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clear  = (state == SEQ_IDLE) && startConv;
    strobe.latch  = (state == SEQ_RUN);
    strobe.commit = (state == SEQ_RUN) && (bitIdx == '0);
  end

  AST_DONE_DROPS_ON_START: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> !convDone); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_RUN && bitIdx != '0) |=> (state == SEQ_RUN && bitIdx == $past(bitIdx) - IW'(1))); // R6

  AST_DONE_AFTER_LSB: assert property (@(posedge clk) disable iff (rst)
    $rose(convDone) |-> $past(state == SEQ_RUN && bitIdx == '0)); // R5

endmodule

// File: rtl/sar_path.sv
module sar_path
  import sar_pkg::*;
#(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  sarStrobe_t    strobe,
  input  logic [IW-1:0] bitIdx,
  input  logic          cmpBelow,
  input  logic          outEn,
  output logic [W-1:0]  dacCode,
  output logic [W-1:0]  dataBus
);

  logic [W-1:0] work;
  logic [W-1:0] result;
  logic [W-1:0] workNext;

  always_comb begin
    workNext = work;
    workNext[bitIdx] = cmpBelow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work   <= '0;
      result <= '0;
    end else begin
      if (strobe.clear) work <= '0;
      else if (strobe.latch) work <= workNext;
      if (strobe.commit) result <= workNext;
    end
  end

  // trial code: decided bits above, 0 under test, 1 below
  for (genvar i = 0; i < W; i++) begin : g_trial
    always_comb begin
      if (!strobe.latch) dacCode[i] = 1'b0;
      else if (IW'(i) > bitIdx) dacCode[i] = work[i];
      else if (IW'(i) == bitIdx) dacCode[i] = 1'b0;
      else dacCode[i] = 1'b1;
    end
  end

  assign dataBus = outEn ? result : '0;

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.commit |=> $stable(result)); // R7

  AST_TEST_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    strobe.latch |-> (dacCode[bitIdx] == 1'b0)); // R3

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         startConv,
  input  logic         cmpBelow,
  input  logic         outEn,
  output logic [W-1:0] dacCode,
  output logic         convDone,
  output logic [W-1:0] dataBus
);

  sarStrobe_t    strobe;
  logic [IW-1:0] bitIdx;

  sar_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .startConv(startConv),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .convDone (convDone)
  );

  sar_path #(.W(W)) u_path (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .bitIdx  (bitIdx),
    .cmpBelow(cmpBelow),
    .outEn   (outEn),
    .dacCode (dacCode),
    .dataBus (dataBus)
  );

endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startConv = 1'b0;
  logic       outEn = 1'b0;
  logic [4:0] vinLvl = '0;
  logic       cmpBelow;
  logic [3:0] dacCode;
  logic       convDone;
  logic [3:0] dataBus;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // digital comparator model: 1 when trial is strictly below the input
  assign cmpBelow = ({1'b0, dacCode} < vinLvl);

  sar_adc_ctrl u0 (
    .clk(clk), .rst(rst), .startConv(startConv), .cmpBelow(cmpBelow),
    .outEn(outEn), .dacCode(dacCode), .convDone(convDone), .dataBus(dataBus)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected trial code for a step, derived from the requirement
  function automatic logic [3:0] trialFor(input int lvl, input int k);
    logic [3:0] decided = 4'(lvl);
    logic [3:0] t = '0;
    for (int i = 0; i < 4; i++) begin
      if (i > k) t[i] = decided[i];
      else if (i == k) t[i] = 1'b0;
      else t[i] = 1'b1;
    end
    return t;
  endfunction

  // full conversion; optional extra start pulse at step stray (-1: none)
  task automatic convert(input int lvl, input int stray, input bit checkTrials);
    vinLvl = 5'(lvl);
    @(negedge clk);
    startConv = 1'b1;
    @(negedge clk);
    startConv = 1'b0;
    check(convDone == 1'b0, "R5 done cleared", int'(convDone), 0);
    for (int k = 3; k >= 0; k--) begin
      if (k != 3) @(negedge clk);
      startConv = (stray == k);
      if (checkTrials)
        check(dacCode == trialFor(lvl, k), "R3 trial code", int'(dacCode), int'(trialFor(lvl, k)));
      check(convDone == 1'b0, "R5 not yet done", int'(convDone), 0);
    end
    @(negedge clk);
    startConv = 1'b0;
    check(convDone == 1'b1, "R5 done after four steps", int'(convDone), 1);
  endtask

  task automatic testReset();
    outEn = 1'b1;
    check(convDone == 1'b0, "R1 done low", int'(convDone), 0);
    check(dataBus == 4'd0, "R1 result zero", int'(dataBus), 0);
    check(dacCode == 4'd0, "R1 idle trial zero", int'(dacCode), 0);
  endtask

  task automatic testExample();
    vinLvl = 5'd2;
    @(negedge clk);
    startConv = 1'b1;
    @(negedge clk);
    startConv = 1'b0;
    check(dacCode == 4'b0111, "R2 first trial", int'(dacCode), 7);
    @(negedge clk);
    check(dacCode == 4'b0011, "R4 second trial", int'(dacCode), 3);
    @(negedge clk);
    check(dacCode == 4'b0001, "R4 third trial", int'(dacCode), 1);
    @(negedge clk);
    check(dacCode == 4'b0010, "R4 fourth trial", int'(dacCode), 2);
    @(negedge clk);
    check(convDone == 1'b1, "R4 done", int'(convDone), 1);
    check(dataBus == 4'b0010, "R4 equality gives 0", int'(dataBus), 2);
  endtask

  task automatic testAllLevels();
    outEn = 1'b1;
    for (int lvl = 0; lvl < 16; lvl++) begin
      convert(lvl, -1, 1'b1);
      check(dataBus == 4'(lvl), "R5 result equals level", int'(dataBus), lvl);
    end
  endtask

  task automatic testStrayStart();
    outEn = 1'b1;
    convert(5, 2, 1'b1);
    check(dataBus == 4'd5, "R6 stray start ignored", int'(dataBus), 5);
    convert(12, 0, 1'b1);
    check(dataBus == 4'd12, "R6 stray start on last step", int'(dataBus), 12);
    @(negedge clk);
    check(dacCode == 4'd0, "R6 no restart", int'(dacCode), 0);
  endtask

  task automatic testStableAndEnable();
    outEn = 1'b1;
    convert(9, -1, 1'b0);
    vinLvl = 5'd4;
    @(negedge clk);
    startConv = 1'b1;
    @(negedge clk);
    startConv = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(dataBus == 4'd9, "R7 old result held", int'(dataBus), 9);
      @(negedge clk);
    end
    check(dataBus == 4'd4, "R7 new result", int'(dataBus), 4);
    outEn = 1'b0;
    #1;
    check(dataBus == 4'd0, "R8 disabled bus zero", int'(dataBus), 0);
    outEn = 1'b1;
    #1;
    check(dataBus == 4'd4, "R8 enabled bus", int'(dataBus), 4);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testExample();
    testAllLevels();
    testStrayStart();
    testStableAndEnable();
    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule